// File: doc/BRIEF.md
# Latched Event Interrupt Controller

This block watches twelve asynchronous status lines and records each one in a sticky latch bit. The latch bits are ANDed with a mask register to drive a single active-low interrupt request. Typical sources are serial handshake lines, an alarm, a wake-up line, a write-protect switch, a data-ready flag and card or line presence events. Every input first passes through a multi-flop synchroniser. Each latch bit is then kept by its own small state machine.

Software reaches three registers over a simple memory-mapped bus. The mask register can be read and written. The latch register is read-only. The clear register is write-only. Writing a one to a clear bit releases the latch bit only once its signal has gone inactive. The data-ready bit has no clear bit. Instead it is released by a one-cycle pulse that reports a read of the serial data register. The write-protect bit has no mask bit.

Each latch bit runs one state machine with three states:
- `EV_IDLE`: not latched.
- `EV_ACTIVE`: latched, with the signal present.
- `EV_HELD`: latched, with the signal gone.

The transitions are:
- IDLE to ACTIVE when the synchronised signal is seen.
- ACTIVE to HELD when the signal drops and no clear is pending.
- ACTIVE to IDLE when the signal drops in the same cycle as a clear request.
- HELD to ACTIVE when the signal returns.
- HELD to IDLE on a clear request while the signal is absent.

In every other case the state is kept.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A latch bit becomes 1 after its input has been high for three clock cycles, and it stays 1 after the input falls until it is cleared.
- R2: A bus write to offset 0x10 releases a latch bit whose data bit is 1 only while that input is low. A data bit of 1 whose input is still high leaves the latch bit at 1. A data bit of 0 never changes the latch.
- R3: `irq_n` is 0 whenever some bit is 1 in both the latch and the mask, and it is 1 otherwise. It follows a change of either register within two cycles.
- R4: Latch bit 7 (data ready) returns to 0 on a `dat_rd_pulse` while input 7 is low. A 1 in bit 7 of a clear write has no effect on it. While input 7 is high, the pulse leaves the bit at 1.
- R5: Latch bit 5 (write protect) latches and clears like the others. Mask bit 5 always reads 0, so bit 5 can never pull `irq_n` low.
- R6: The mask is at offset 0x04, the latch at 0x0C and the clear register at 0x10. Mask and latch reset to 0x0000 and `irq_n` resets to 1. Reads at offset 0x10 return 0. Writes at offset 0x0C change neither the latch nor the mask.
- R7: The bit map is: bits 0 to 3 for CTS, DSR, DCD and RI; bit 4 for alarm; bit 5 for write protect; bit 6 for wake-up; bit 7 for data ready; bits 8 to 11 for card detect, inverted card detect, line invalid and inverted line invalid. Bits 12 to 15 read as 0 in both the mask and the latch.
- R8: Read data appears on `bus_rdata` in the cycle after the read strobe, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 12 | Asynchronous status inputs, active high |
| dat_rd_pulse | input | 1 | One-cycle pulse: the serial data register was read |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with the default two-stage synchroniser and the default twelve events, so the cycle-exact capture of a three-cycle input pulse can be observed. With these values, both corners of the gated clear are reachable: a clear while the input is high, and a clear after it has dropped. The bench also covers both exceptions to the normal bit behaviour: write protect, which has no mask bit, and data ready, which has no clear bit and is released by the read pulse.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int EVT_N   = 12;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int BIT_WP  = 5;
    localparam int BIT_RDY = 7;

    localparam logic [ADDR_W-1:0] OFS_MASK  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_LATCH = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CLEAR = 5'h10;

    // Bits that physically exist in the mask and clear registers.
    localparam logic [DATA_W-1:0] LIVE_BITS = DATA_W'((1 << EVT_N) - 1);
    localparam logic [DATA_W-1:0] MASK_IMPL = LIVE_BITS & ~(DATA_W'(1) << BIT_WP);
    localparam logic [DATA_W-1:0] CLR_IMPL  = LIVE_BITS & ~(DATA_W'(1) << BIT_RDY);

    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_ACTIVE = 2'd1,
        EV_HELD   = 2'd2
    } ev_state_t;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int WIDTH  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/evt_cell.sv
module evt_cell
    import evt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic clr,
    output logic latched
);
    ev_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:   if (act) state_d = EV_ACTIVE;
            EV_ACTIVE: if (!act) state_d = clr ? EV_IDLE : EV_HELD;
            EV_HELD:   if (act) state_d = EV_ACTIVE;
                       else if (clr) state_d = EV_IDLE;
            default:   state_d = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        latched = (state_q != EV_IDLE);
    end

    // R1: an active level sets the bit
    a_r1_set: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> latched);
    // R1: without a clear request the bit holds
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !clr) |=> latched);
    // R2: a clear on an inactive signal releases the bit
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && clr && !act) |=> !latched);
endmodule

// File: rtl/evt_regs.sv
module evt_regs
    import evt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [EVT_N-1:0]  latch_vec,
    output logic [EVT_N-1:0]  clr_vec,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n
);
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] rdata_q;
    logic              irq_q;
    logic [DATA_W-1:0] latch_wide;
    logic [DATA_W-1:0] clr_full;
    logic              unused_hi;
    logic              wr_mask, wr_clear, rd_any;

    assign latch_wide = {{(DATA_W-EVT_N){1'b0}}, latch_vec};
    assign wr_mask    = bus_sel && bus_wr && (bus_addr == OFS_MASK);
    assign wr_clear   = bus_sel && bus_wr && (bus_addr == OFS_CLEAR);
    assign rd_any     = bus_sel && !bus_wr;
    assign clr_full   = wr_clear ? (bus_wdata & CLR_IMPL) : '0;
    assign clr_vec    = clr_full[EVT_N-1:0];
    assign unused_hi  = ^clr_full[DATA_W-1:EVT_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= bus_wdata & MASK_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_any) begin
            unique case (bus_addr)
                OFS_MASK:  rdata_q <= mask_q;
                OFS_LATCH: rdata_q <= latch_wide;
                default:   rdata_q <= '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b1;
        else        irq_q <= ~|(latch_wide & mask_q);
    end

    assign bus_rdata = rdata_q;
    assign irq_n     = irq_q;

    // R3: a masked latched bit pulls the line low next cycle
    a_r3_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        (|(latch_wide & mask_q)) |=> !irq_n);
    // R3: nothing pending releases the line
    a_r3_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(latch_wide & mask_q)) |=> irq_n);
    // R6: the clear register reads as zero
    a_r6_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && bus_addr == OFS_CLEAR) |=> (bus_rdata == '0));
    // R6: writes elsewhere leave the mask alone
    a_r6_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr != OFS_MASK) |=> $stable(mask_q));
    // R8: read data holds between reads
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> $stable(bus_rdata));
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_N-1:0]  evt_in,
    input  logic              dat_rd_pulse,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n
);
    logic [EVT_N-1:0] evt_sync_v;
    logic [EVT_N-1:0] clr_req;
    logic [EVT_N-1:0] latch_v;

    evt_sync #(.WIDTH(EVT_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (evt_in),
        .sync_out (evt_sync_v)
    );

    genvar i;
    generate
        for (i = 0; i < EVT_N; i++) begin : g_cell
            logic cell_clr;
            if (i == BIT_RDY) begin : g_auto
                assign cell_clr = dat_rd_pulse;
            end else begin : g_sw
                assign cell_clr = clr_req[i];
            end
            evt_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .act     (evt_sync_v[i]),
                .clr     (cell_clr),
                .latched (latch_v[i])
            );
        end
    endgenerate

    evt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .latch_vec (latch_v),
        .clr_vec   (clr_req),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );
endmodule

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt_in = '0;
    logic        dat_rd_pulse = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    localparam logic [4:0] A_MASK = 5'h04, A_LATCH = 5'h0C, A_CLEAR = 5'h10;

    always #2 clk = ~clk;

    evt_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .dat_rd_pulse(dat_rd_pulse),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_irq(input logic exp, input string tag);
        n_tests++;
        if (irq_n !== exp) begin
            n_fail++;
            $display("FAIL %s irq_n actual=%b expected=%b", tag, irq_n, exp);
        end
    endtask

    task automatic pulse_rd();
        @(negedge clk);
        dat_rd_pulse = 1'b1;
        @(negedge clk);
        dat_rd_pulse = 1'b0;
    endtask

    // Monitor: compares read data one cycle after each read strobe (R8)
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && bus_sel && !bus_wr) begin
                @(negedge clk);
                if (exp_q.size() > 0) begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    n_tests++;
                    if (bus_rdata !== e) begin
                        n_fail++;
                        $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R6 reset state
        check_irq(1'b1, "R6 reset irq_n");
        bus_read(A_MASK,  16'h0000, "R6 reset mask");
        bus_read(A_LATCH, 16'h0000, "R6 reset latch");

        // R5 / R7 mask implemented bits
        bus_write(A_MASK, 16'hFFFF);
        bus_read(A_MASK, 16'h0FDF, "R7 mask upper bits and R5 bit5");
        bus_write(A_MASK, 16'h0000);

        // R1 set and hold, CTS at bit 0
        evt_in[0] = 1'b1;
        idle(5);
        bus_read(A_LATCH, 16'h0001, "R1 set bit0");
        check_irq(1'b1, "R3 masked off");
        evt_in[0] = 1'b0;
        idle(5);
        bus_read(A_LATCH, 16'h0001, "R1 hold after input drop");

        // R3 mask enables interrupt
        bus_write(A_MASK, 16'h0001);
        idle(3);
        check_irq(1'b0, "R3 masked pending");
        bus_write(A_CLEAR, 16'h0000);
        idle(2);
        bus_read(A_LATCH, 16'h0001, "R2 zero write no effect");

        // R2 clear blocked while active, DCD at bit 2
        evt_in[2] = 1'b1;
        idle(5);
        bus_write(A_CLEAR, 16'h0004);
        idle(2);
        bus_read(A_LATCH, 16'h0005, "R2 clear while active ignored");
        bus_write(A_CLEAR, 16'h0001);
        idle(2);
        bus_read(A_LATCH, 16'h0004, "R2 clear inactive bit0");
        check_irq(1'b1, "R3 no masked pending");
        evt_in[2] = 1'b0;
        idle(5);
        bus_write(A_CLEAR, 16'h0004);
        idle(2);
        bus_read(A_LATCH, 16'h0000, "R2 clear after drop");

        // R6 latch read-only, clear reads zero
        bus_write(A_LATCH, 16'hFFFF);
        idle(2);
        bus_read(A_LATCH, 16'h0000, "R6 latch write ignored");
        bus_read(A_MASK,  16'h0001, "R6 mask unchanged by latch write");
        bus_read(A_CLEAR, 16'h0000, "R6 clear reads zero");

        // R5 write protect: latches, no mask, clears
        bus_write(A_MASK, 16'hFFFF);
        evt_in[5] = 1'b1;
        idle(5);
        evt_in[5] = 1'b0;
        idle(5);
        bus_read(A_LATCH, 16'h0020, "R5 wp latched");
        check_irq(1'b1, "R5 wp cannot interrupt");
        bus_write(A_CLEAR, 16'h0020);
        idle(2);
        bus_read(A_LATCH, 16'h0000, "R5 wp cleared");

        // R4 data ready
        evt_in[7] = 1'b1;
        idle(5);
        pulse_rd();
        idle(2);
        bus_read(A_LATCH, 16'h0080, "R4 pulse while active ignored");
        evt_in[7] = 1'b0;
        idle(5);
        check_irq(1'b0, "R4 ready interrupts");
        bus_write(A_CLEAR, 16'h0080);
        idle(2);
        bus_read(A_LATCH, 16'h0080, "R4 clear write ignored");
        pulse_rd();
        idle(3);
        bus_read(A_LATCH, 16'h0000, "R4 auto clear on read pulse");
        check_irq(1'b1, "R4 irq released");

        // R7 / R1 group pattern and short pulse
        evt_in[11:8] = 4'hF;
        @(negedge clk); @(negedge clk); @(negedge clk);
        evt_in[11:8] = 4'h0;
        idle(5);
        bus_read(A_LATCH, 16'h0F00, "R1 three-cycle pulse bits 8-11");
        check_irq(1'b0, "R3 group pending");
        bus_write(A_CLEAR, 16'hFFFF);
        idle(3);
        bus_read(A_LATCH, 16'h0000, "R2 clear all");
        check_irq(1'b1, "R3 all cleared");

        idle(4);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule